// File: doc/BRIEF.md
# Requester-Aware Posted Write Reordering Queue

This block is an eight-slot transaction queue that sits between a request source and a downstream link. Each slot holds a request type (memory write, memory read, configuration or I/O), a requester identifier, a three-bit attribute field, a destination select and an opaque tag. Every cycle the queue picks the oldest slot that is allowed to leave and offers it on the issue port.

A destination can be stalled through a per-destination input. A stalled destination blocks its own slots. By default it also blocks every younger slot, so the queue drains in strict arrival order. When the ordering enable is high, a memory write whose identifier-ordering attribute (bit 2) is set may go past older memory writes from other requesters. It never goes past anything from its own requester, and it never goes past an older read, configuration or I/O request. This lets a completion flag written by one engine wait behind that engine's own peer-memory write, while traffic from unrelated requesters keeps moving.

Top module: `idoq_txn_queue`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `enq_ready` is 1.
- R2: A request is stored when `enq_valid` and `enq_ready` are both high at a clock edge. `enq_ready` is 0 while eight requests are held, and a request offered then is dropped.
- R3: With `ido_en` low, requests issue strictly in arrival order, and an oldest request whose destination is stalled blocks all others.
- R4: With `ido_en` high, a memory write (type code 0) whose attribute bit 2 is 1 may issue ahead of older memory writes that carry a different requester ID.
- R5: A request never issues ahead of an older request with the same requester ID, whatever its attributes.
- R6: Attribute bit 2 has no effect on reads (code 1), configuration (code 2) or I/O (code 3) requests, and no request passes an older non-write.
- R7: The issue port presents the oldest eligible request, so the oldest entry is taken whenever it is eligible.
- R8: `iss_valid` is 1 exactly when at least one held request is eligible, and it is never 1 for a request whose destination is stalled.
- R9: Attribute bit 1 (relaxed ordering) alone grants no passing. Of the codes 3'b000, 3'b010, 3'b100 and 3'b110, only the two with bit 2 set allow passing.
- R10: A memory write with attribute bit 2 clear never passes an older request, even from a different requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ido_en | input | 1 | Global enable for identifier-based passing |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | Queue can accept a request |
| enq_kind | input | 2 | Type: 0 write, 1 read, 2 config, 3 I/O |
| enq_rid | input | RID_W | Requester identifier |
| enq_attr | input | 3 | Attributes: bit 2 ID ordering, bit 1 relaxed |
| enq_dst | input | DST_W | Destination select |
| enq_tag | input | TAG_W | Opaque request tag |
| dst_stall | input | DST_N | Per-destination back-pressure |
| iss_valid | output | 1 | An eligible request is offered |
| iss_ready | input | 1 | Downstream takes the offered request |
| iss_kind | output | 2 | Type of offered request |
| iss_rid | output | RID_W | Requester of offered request |
| iss_attr | output | 3 | Attributes of offered request |
| iss_dst | output | DST_W | Destination of offered request |
| iss_tag | output | TAG_W | Tag of offered request |

## Verification
Slot compaction is the most likely place for internal state to go wrong. A missed shift or a misplaced write shows up at the issue port on the very next offer, as a wrong or repeated tag. A wrong occupancy count shows as `enq_ready` or `iss_valid` disagreeing with the number of accepted and issued requests, within the same cycle. Ordering faults show in the cycle a destination is stalled: a younger tag is offered when it should not be, or the port stays idle when a legal pass exists. The directed scenarios therefore stall one destination and check which tag is offered first.

// File: rtl/idoq_pkg.sv
package idoq_pkg;
  typedef enum logic [1:0] {
    K_MWR = 2'd0,
    K_MRD = 2'd1,
    K_CFG = 2'd2,
    K_IO  = 2'd3
  } kind_e;

  localparam int ATTR_W  = 3;
  localparam int IDO_BIT = 2;
  localparam int RO_BIT  = 1;
endpackage

// File: rtl/idoq_rst_sync.sv
module idoq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/idoq_pass_rule.sv
module idoq_pass_rule
  import idoq_pkg::*;
#(
  parameter int RID_W = 16
) (
  input  logic             en,
  input  logic [1:0]       yng_kind,
  input  logic             yng_ido,
  input  logic [RID_W-1:0] yng_rid,
  input  logic [1:0]       old_kind,
  input  logic [RID_W-1:0] old_rid,
  output logic             pass
);
  logic yng_write;
  logic old_write;
  logic rid_differs;

  assign yng_write   = (yng_kind == K_MWR);
  assign old_write   = (old_kind == K_MWR);
  assign rid_differs = (yng_rid != old_rid);
  assign pass        = en & yng_write & yng_ido & old_write & rid_differs;
endmodule

// File: rtl/idoq_select.sv
module idoq_select #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && !found) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign any = |elig;
endmodule

// File: rtl/idoq_store.sv
module idoq_store #(
  parameter int DEPTH = 8,
  parameter int RID_W = 16,
  parameter int TAG_W = 8,
  parameter int DST_W = 1,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [1:0]                  push_kind,
  input  logic [RID_W-1:0]            push_rid,
  input  logic [2:0]                  push_attr,
  input  logic [DST_W-1:0]            push_dst,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic                        pop,
  input  logic [IDX_W-1:0]            pop_idx,
  output logic [DEPTH-1:0]            vld,
  output logic                        full,
  output logic [DEPTH-1:0][1:0]       kind_q,
  output logic [DEPTH-1:0][RID_W-1:0] rid_q,
  output logic [DEPTH-1:0][2:0]       attr_q,
  output logic [DEPTH-1:0][DST_W-1:0] dst_q,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_q
);
  logic [CNT_W-1:0] count_q, count_d, wr_pos;
  logic             ce;

  logic [DEPTH-1:0][1:0]       kind_d;
  logic [DEPTH-1:0][RID_W-1:0] rid_d;
  logic [DEPTH-1:0][2:0]       attr_d;
  logic [DEPTH-1:0][DST_W-1:0] dst_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_d;

  logic [DEPTH:0][1:0]       kind_ext;
  logic [DEPTH:0][RID_W-1:0] rid_ext;
  logic [DEPTH:0][2:0]       attr_ext;
  logic [DEPTH:0][DST_W-1:0] dst_ext;
  logic [DEPTH:0][TAG_W-1:0] tag_ext;

  assign kind_ext = {2'b00, kind_q};
  assign rid_ext  = {{RID_W{1'b0}}, rid_q};
  assign attr_ext = {3'b000, attr_q};
  assign dst_ext  = {{DST_W{1'b0}}, dst_q};
  assign tag_ext  = {{TAG_W{1'b0}}, tag_q};

  assign ce      = push | pop;
  assign wr_pos  = count_q - CNT_W'(pop);
  assign count_d = count_q + CNT_W'(push) - CNT_W'(pop);
  assign full    = (count_q == CNT_W'(DEPTH));

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic shift_in;
    logic load;
    assign shift_in  = pop & (IDX_W'(s) >= pop_idx);
    assign load      = push & (wr_pos == CNT_W'(s));
    assign vld[s]    = (CNT_W'(s) < count_q);
    assign kind_d[s] = load ? push_kind : (shift_in ? kind_ext[s+1] : kind_q[s]);
    assign rid_d[s]  = load ? push_rid  : (shift_in ? rid_ext[s+1]  : rid_q[s]);
    assign attr_d[s] = load ? push_attr : (shift_in ? attr_ext[s+1] : attr_q[s]);
    assign dst_d[s]  = load ? push_dst  : (shift_in ? dst_ext[s+1]  : dst_q[s]);
    assign tag_d[s]  = load ? push_tag  : (shift_in ? tag_ext[s+1]  : tag_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count_q <= '0;
    else if (ce) count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      kind_q <= kind_d;
      rid_q  <= rid_d;
      attr_q <= attr_d;
      dst_q  <= dst_d;
      tag_q  <= tag_d;
    end
  end
endmodule

// File: rtl/idoq_txn_queue.sv
module idoq_txn_queue
  import idoq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int RID_W = 16,
  parameter  int TAG_W = 8,
  parameter  int DST_N = 2,
  localparam int DST_W = (DST_N > 1) ? $clog2(DST_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ido_en,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [1:0]       enq_kind,
  input  logic [RID_W-1:0] enq_rid,
  input  logic [2:0]       enq_attr,
  input  logic [DST_W-1:0] enq_dst,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic [DST_N-1:0] dst_stall,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [1:0]       iss_kind,
  output logic [RID_W-1:0] iss_rid,
  output logic [2:0]       iss_attr,
  output logic [DST_W-1:0] iss_dst,
  output logic [TAG_W-1:0] iss_tag
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic rst_sync_n;
  logic push, pop, full;
  logic [IDX_W-1:0] sel_idx;
  logic [DEPTH-1:0] vld, blk, elig;

  logic [DEPTH-1:0][1:0]       kind_q;
  logic [DEPTH-1:0][RID_W-1:0] rid_q;
  logic [DEPTH-1:0][2:0]       attr_q;
  logic [DEPTH-1:0][DST_W-1:0] dst_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0][DEPTH-1:0] pass_m;

  idoq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign enq_ready = rst_sync_n & ~full;
  assign push      = enq_valid & enq_ready;
  assign pop       = iss_valid & iss_ready;

  idoq_store #(
    .DEPTH (DEPTH), .RID_W (RID_W), .TAG_W (TAG_W),
    .DST_W (DST_W), .IDX_W (IDX_W), .CNT_W (CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_kind (enq_kind),
    .push_rid  (enq_rid),
    .push_attr (enq_attr),
    .push_dst  (enq_dst),
    .push_tag  (enq_tag),
    .pop       (pop),
    .pop_idx   (sel_idx),
    .vld       (vld),
    .full      (full),
    .kind_q    (kind_q),
    .rid_q     (rid_q),
    .attr_q    (attr_q),
    .dst_q     (dst_q),
    .tag_q     (tag_q)
  );

  // pass_m[y][o]: slot y may leave ahead of older slot o
  for (genvar y = 0; y < DEPTH; y++) begin : g_yng
    for (genvar o = 0; o < DEPTH; o++) begin : g_old
      if (o < y) begin : g_rule
        idoq_pass_rule #(.RID_W (RID_W)) u_rule (
          .en       (ido_en),
          .yng_kind (kind_q[y]),
          .yng_ido  (attr_q[y][IDO_BIT]),
          .yng_rid  (rid_q[y]),
          .old_kind (kind_q[o]),
          .old_rid  (rid_q[o]),
          .pass     (pass_m[y][o])
        );
      end else begin : g_none
        assign pass_m[y][o] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int y = 0; y < DEPTH; y++) begin
      blk[y] = 1'b0;
      for (int o = 0; o < DEPTH; o++) begin
        if (vld[o] && !pass_m[y][o]) blk[y] = 1'b1;
      end
      elig[y] = vld[y] & ~dst_stall[dst_q[y]] & ~blk[y];
    end
  end

  idoq_select #(.DEPTH (DEPTH), .IDX_W (IDX_W)) u_sel (
    .elig (elig),
    .any  (iss_valid),
    .idx  (sel_idx)
  );

  assign iss_kind = kind_q[sel_idx];
  assign iss_rid  = rid_q[sel_idx];
  assign iss_attr = attr_q[sel_idx];
  assign iss_dst  = dst_q[sel_idx];
  assign iss_tag  = tag_q[sel_idx];
endmodule

// File: rtl/idoq_checker.sv
module idoq_checker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int DST_N = 2,
  parameter int DST_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ido_en,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic [DST_N-1:0] dst_stall,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       iss_kind,
  input logic             iss_ido,
  input logic [DST_W-1:0] iss_dst,
  input logic [IDX_W-1:0] sel_idx
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(enq_valid & enq_ready) - CW'(iss_valid & iss_ready);
  end

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) |-> !enq_ready);
  assert_valid_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (cnt_q != '0));
  assert_no_stalled_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !dst_stall[iss_dst]);
  assert_strict_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !ido_en) |-> (sel_idx == '0));
  assert_nonwrite_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_kind != 2'd0) |-> (sel_idx == '0));
  assert_plain_write_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ido) |-> (sel_idx == '0));
endmodule

bind idoq_txn_queue idoq_checker #(
  .DEPTH (DEPTH), .IDX_W (IDX_W), .DST_N (DST_N), .DST_W (DST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ido_en    (ido_en),
  .enq_valid (enq_valid),
  .enq_ready (enq_ready),
  .dst_stall (dst_stall),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_kind  (iss_kind),
  .iss_ido   (iss_attr[2]),
  .iss_dst   (iss_dst),
  .sel_idx   (sel_idx)
);

// File: tb/idoq_txn_queue_bench.sv
module idoq_txn_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RID_W = 16;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ido_en = 1'b0;
  logic enq_valid = 1'b0;
  logic enq_ready;
  logic [1:0] enq_kind = 2'd0;
  logic [RID_W-1:0] enq_rid = '0;
  logic [2:0] enq_attr = 3'd0;
  logic [0:0] enq_dst = 1'b0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic [1:0] dst_stall = 2'b00;
  logic iss_valid;
  logic iss_ready = 1'b0;
  logic [1:0] iss_kind;
  logic [RID_W-1:0] iss_rid;
  logic [2:0] iss_attr;
  logic [0:0] iss_dst;
  logic [TAG_W-1:0] iss_tag;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idoq_txn_queue u_idoq_txn_queue (
    .clk (clk), .rst_n (rst_n), .ido_en (ido_en),
    .enq_valid (enq_valid), .enq_ready (enq_ready), .enq_kind (enq_kind),
    .enq_rid (enq_rid), .enq_attr (enq_attr), .enq_dst (enq_dst), .enq_tag (enq_tag),
    .dst_stall (dst_stall), .iss_valid (iss_valid), .iss_ready (iss_ready),
    .iss_kind (iss_kind), .iss_rid (iss_rid), .iss_attr (iss_attr),
    .iss_dst (iss_dst), .iss_tag (iss_tag)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enq(input logic [1:0] k, input logic [RID_W-1:0] rid,
                     input logic [2:0] a, input logic d, input logic [TAG_W-1:0] tag);
    enq_kind = k; enq_rid = rid; enq_attr = a; enq_dst = d; enq_tag = tag;
    enq_valid = 1'b1;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [TAG_W-1:0] tag, input string req);
    chk(iss_valid === 1'b1, req, int'(iss_valid), 1);
    chk(iss_tag === tag, req, int'(iss_tag), int'(tag));
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic expect_idle(input string req);
    chk(iss_valid === 1'b0, req, int'(iss_valid), 0);
  endtask

  task automatic t_reset;
    chk(iss_valid === 1'b0, "R1", int'(iss_valid), 0);
    chk(enq_ready === 1'b1, "R1", int'(enq_ready), 1);
  endtask

  task automatic t_strict;
    ido_en = 1'b0; dst_stall = 2'b01;
    enq(2'd0, 16'h0001, 3'b100, 1'b0, 8'h10);
    enq(2'd0, 16'h0002, 3'b100, 1'b1, 8'h11);
    expect_idle("R3 stalled head blocks");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h10, "R3 order first");
    pop_expect(8'h11, "R3 order second");
    expect_idle("R3 drained");
  endtask

  task automatic t_ido_pass;
    ido_en = 1'b1; dst_stall = 2'b01;
    enq(2'd0, 16'h0001, 3'b000, 1'b0, 8'h20);
    enq(2'd0, 16'h0002, 3'b100, 1'b1, 8'h21);
    pop_expect(8'h21, "R4 pass other rid");
    expect_idle("R8 only stalled left");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h20, "R4 stalled one after");
  endtask

  task automatic t_same_rid;
    ido_en = 1'b1; dst_stall = 2'b01;
    enq(2'd0, 16'h0033, 3'b000, 1'b0, 8'h30);
    enq(2'd0, 16'h0033, 3'b110, 1'b1, 8'h31);
    expect_idle("R5 flag waits for peer write");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h30, "R5 peer first");
    pop_expect(8'h31, "R5 flag second");
  endtask

  task automatic t_nonmem;
    ido_en = 1'b1; dst_stall = 2'b01;
    enq(2'd0, 16'h0001, 3'b000, 1'b0, 8'h40);
    enq(2'd2, 16'h0002, 3'b100, 1'b1, 8'h41);
    expect_idle("R6 config ignores attr");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h40, "R6 order a");
    pop_expect(8'h41, "R6 order b");
    dst_stall = 2'b01;
    enq(2'd1, 16'h0001, 3'b000, 1'b0, 8'h42);
    enq(2'd0, 16'h0002, 3'b100, 1'b1, 8'h43);
    expect_idle("R6 no pass of older read");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h42, "R6 read first");
    pop_expect(8'h43, "R6 write second");
  endtask

  task automatic t_attr_codes;
    logic [2:0] codes [4] = '{3'b000, 3'b010, 3'b100, 3'b110};
    ido_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      dst_stall = 2'b01;
      enq(2'd0, 16'h0001, 3'b000, 1'b0, 8'h50);
      enq(2'd0, 16'h0002, codes[c], 1'b1, 8'h51);
      if (codes[c][2]) begin
        pop_expect(8'h51, "R9 id bit passes");
        dst_stall = 2'b00; @(negedge clk);
        pop_expect(8'h50, "R9 older after");
      end else begin
        expect_idle(codes[c][1] ? "R9 relaxed alone no pass" : "R10 plain write no pass");
        dst_stall = 2'b00; @(negedge clk);
        pop_expect(8'h50, "R10 order a");
        pop_expect(8'h51, "R10 order b");
      end
    end
  endtask

  task automatic t_oldest;
    ido_en = 1'b1; dst_stall = 2'b01;
    enq(2'd0, 16'h0001, 3'b000, 1'b0, 8'h60);
    enq(2'd0, 16'h0002, 3'b100, 1'b1, 8'h61);
    enq(2'd0, 16'h0004, 3'b100, 1'b1, 8'h62);
    pop_expect(8'h61, "R7 oldest eligible");
    pop_expect(8'h62, "R7 next eligible");
    dst_stall = 2'b00; @(negedge clk);
    pop_expect(8'h60, "R7 head last");
    enq(2'd0, 16'h0001, 3'b000, 1'b0, 8'h63);
    enq(2'd0, 16'h0002, 3'b100, 1'b1, 8'h64);
    pop_expect(8'h63, "R7 head preferred");
    pop_expect(8'h64, "R7 then younger");
  endtask

  task automatic t_full;
    ido_en = 1'b0; dst_stall = 2'b00;
    for (int i = 0; i < 8; i++) enq(2'd0, 16'(i), 3'b000, 1'(i), 8'(8'h70 + i));
    chk(enq_ready === 1'b0, "R2 full", int'(enq_ready), 0);
    enq(2'd0, 16'h00ff, 3'b000, 1'b0, 8'h99);
    dst_stall = 2'b11; @(negedge clk);
    expect_idle("R8 all stalled");
    dst_stall = 2'b00; @(negedge clk);
    for (int i = 0; i < 8; i++) pop_expect(8'(8'h70 + i), "R2 drain order");
    expect_idle("R2 extra request dropped");
    chk(enq_ready === 1'b1, "R2 ready after drain", int'(enq_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_strict();
    t_ido_pass();
    t_same_rid();
    t_nonmem();
    t_attr_codes();
    t_oldest();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule